// File: doc/BRIEF.md
# Banked Integer Register File with Privileged Overlay

This block holds the general-purpose integer registers of a 64-bit core. Each register is 64 bits wide, 31 of them can be addressed, and a fixed number names a constant zero. The block has two read ports and one write port. Each port takes a 5-bit register number.

A privileged-mode input swaps a subset of register numbers onto a private bank of eight overlay registers. While the flag is high, numbers 8 to 14 and number 25 reach the overlay bank. Every other number still reaches the ordinary bank. When the flag is low, all numbers reach the ordinary bank. Privileged code can therefore use those registers as scratch without saving the interrupted context. The core drives the mode flag, and the core also takes care of forwarding results between pipeline stages.

Reads are combinational from stored state. A write is captured on the rising clock edge and is visible to reads in the next cycle.

Top module: `shrf_top`

## Requirements
- R1: A synchronous active-high reset clears every ordinary and overlay register, so every read returns 0 after reset.
- R2: With `priv_mode` low, register numbers 0 to 30, including 8 to 14 and 25, read and write the ordinary bank.
- R3: With `priv_mode` high, register numbers 8 to 14 read and write overlay entries 0 to 6, in that order.
- R4: With `priv_mode` high, register number 25 reads and writes overlay entry 7.
- R5: With `priv_mode` high, register numbers outside 8 to 14 and 25 reach the same ordinary registers as in non-privileged mode.
- R6: Register number 31 always reads 0 on both ports, and a write to it changes no register.
- R7: A privileged write to a redirected number leaves the ordinary register of that number unchanged. The ordinary value reads back once `priv_mode` is low again.
- R8: A write is visible to reads from the cycle after its clock edge. A read of the register being written in the same cycle returns the old value.
- R9: The two read ports are independent and may name the same or different registers in the same cycle.
- R10: When `wr_en` is low, no register changes, whatever `wr_num` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 1 | High selects the overlay bank for redirected numbers |
| rd_num_a | input | 5 | Register number for read port A |
| rd_data_a | output | 64 | Read data for port A |
| rd_num_b | input | 5 | Register number for read port B |
| rd_data_b | output | 64 | Read data for port B |
| wr_en | input | 1 | Write enable |
| wr_num | input | 5 | Register number for the write |
| wr_data | input | 64 | Write data |

## Verification
The hardest case to reach from the ports is a single register number that holds two different live values. This happens when the number was written once with `priv_mode` low and once with it high, and is then read under both settings. The directed stimulus builds this case on register 9 and register 25. The random phase toggles the mode often and concentrates register numbers in the redirected window, so that ordinary and overlay copies keep diverging and are cross-read by the opposite mode.

// File: rtl/shrf_pkg.sv
package shrf_pkg;

    localparam int unsigned REG_NUM_W   = 5;
    localparam int unsigned ZERO_NUM    = 31;
    localparam int unsigned WIN_LO      = 8;
    localparam int unsigned WIN_HI      = 14;
    localparam int unsigned EXTRA_NUM   = 25;
    localparam int unsigned OVL_DEPTH   = 8;
    localparam int unsigned NORM_DEPTH  = 31;

    typedef logic [REG_NUM_W-1:0] reg_num_t;

    // Where a register number lands after the mode-dependent steering.
    typedef struct packed {
        logic     is_zero;
        logic     in_overlay;
        reg_num_t slot;
    } rf_loc_t;

    function automatic logic redirected(input reg_num_t num);
        return ((32'(num) >= WIN_LO) && (32'(num) <= WIN_HI)) || (32'(num) == EXTRA_NUM);
    endfunction

    function automatic rf_loc_t locate(input logic priv, input reg_num_t num);
        rf_loc_t l;
        l.is_zero    = (32'(num) == ZERO_NUM);
        l.in_overlay = 1'b0;
        l.slot       = num;
        if (priv && redirected(num)) begin
            l.in_overlay = 1'b1;
            if (32'(num) == EXTRA_NUM)
                l.slot = reg_num_t'(OVL_DEPTH - 1);
            else
                l.slot = num - reg_num_t'(WIN_LO);
        end
        return l;
    endfunction

endpackage

// File: rtl/shrf_remap.sv
module shrf_remap
    import shrf_pkg::*;
(
    input  logic     priv,
    input  reg_num_t num,
    output rf_loc_t  loc
);
    always_comb loc = locate(priv, num);
endmodule

// File: rtl/shrf_bank.sv
module shrf_bank #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned DEPTH = 31,
    parameter int unsigned NRD   = 2,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [WIDTH-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]     raddr,
    output logic [NRD-1:0][WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (we && (32'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
        always_comb begin
            rdata[p] = '0;
            if (32'(raddr[p]) < DEPTH) rdata[p] = mem[raddr[p]];
        end
    end

    // R8: an accepted write is held in the addressed entry one edge later
    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        (we && (32'(waddr) < DEPTH)) |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/shrf_top.sv
module shrf_top
    import shrf_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            priv_mode,
    input  logic [4:0]      rd_num_a,
    output logic [XLEN-1:0] rd_data_a,
    input  logic [4:0]      rd_num_b,
    output logic [XLEN-1:0] rd_data_b,
    input  logic            wr_en,
    input  logic [4:0]      wr_num,
    input  logic [XLEN-1:0] wr_data
);
    localparam int unsigned NRD   = 2;
    localparam int unsigned N_AW  = $clog2(NORM_DEPTH);
    localparam int unsigned O_AW  = $clog2(OVL_DEPTH);

    reg_num_t [NRD-1:0]              rd_num;
    rf_loc_t  [NRD-1:0]              rd_loc;
    logic     [NRD-1:0][N_AW-1:0]    norm_raddr;
    logic     [NRD-1:0][O_AW-1:0]    ovl_raddr;
    logic     [NRD-1:0][XLEN-1:0]    norm_rdata;
    logic     [NRD-1:0][XLEN-1:0]    ovl_rdata;
    logic     [NRD-1:0][XLEN-1:0]    rd_data;
    rf_loc_t                         wr_loc;
    logic                            norm_we;
    logic                            ovl_we;

    assign rd_num[0] = rd_num_a;
    assign rd_num[1] = rd_num_b;
    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    for (genvar p = 0; p < int'(NRD); p++) begin : g_port
        shrf_remap u_map (.priv(priv_mode), .num(rd_num[p]), .loc(rd_loc[p]));
        assign norm_raddr[p] = N_AW'(rd_loc[p].slot);
        assign ovl_raddr[p]  = rd_loc[p].slot[O_AW-1:0];
        always_comb begin
            if (rd_loc[p].is_zero)         rd_data[p] = '0;
            else if (rd_loc[p].in_overlay) rd_data[p] = ovl_rdata[p];
            else                           rd_data[p] = norm_rdata[p];
        end
    end

    shrf_remap u_wmap (.priv(priv_mode), .num(wr_num), .loc(wr_loc));

    assign norm_we = wr_en && !wr_loc.is_zero && !wr_loc.in_overlay;
    assign ovl_we  = wr_en && !wr_loc.is_zero &&  wr_loc.in_overlay;

    shrf_bank #(.WIDTH(XLEN), .DEPTH(NORM_DEPTH), .NRD(NRD)) u_norm (
        .clk(clk), .rst(rst), .we(norm_we), .waddr(N_AW'(wr_loc.slot)),
        .wdata(wr_data), .raddr(norm_raddr), .rdata(norm_rdata));

    shrf_bank #(.WIDTH(XLEN), .DEPTH(OVL_DEPTH), .NRD(NRD)) u_ovl (
        .clk(clk), .rst(rst), .we(ovl_we), .waddr(wr_loc.slot[O_AW-1:0]),
        .wdata(wr_data), .raddr(ovl_raddr), .rdata(ovl_rdata));

    // R6: number 31 reads zero on both ports
    p_zero_a_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_num_a == 5'd31) |-> (rd_data_a == '0));
    p_zero_b_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_num_b == 5'd31) |-> (rd_data_b == '0));
    // R7: privileged writes to redirected numbers never reach the ordinary bank
    p_ovl_isolates_r7: assert property (@(posedge clk) disable iff (rst)
        (priv_mode && ((wr_num >= 5'd8 && wr_num <= 5'd14) || wr_num == 5'd25)) |-> !norm_we);
    // R2: outside privileged mode the overlay bank is never written
    p_no_ovl_write_r2: assert property (@(posedge clk) disable iff (rst)
        !priv_mode |-> !ovl_we);
    // R10: no bank write without the enable
    p_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (!norm_we && !ovl_we));

endmodule

// File: tb/sim_shrf_top.sv
`timescale 1ns/1ps
module sim_shrf_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        priv_mode;
    logic [4:0]  rd_num_a, rd_num_b, wr_num;
    logic [63:0] rd_data_a, rd_data_b, wr_data;
    logic        wr_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] m_norm [31];
    logic [63:0] m_ovl  [8];

    always #2.5 clk = ~clk;

    shrf_top u0 (
        .clk(clk), .rst(rst), .priv_mode(priv_mode),
        .rd_num_a(rd_num_a), .rd_data_a(rd_data_a),
        .rd_num_b(rd_num_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data));

    function automatic logic [63:0] model_rd(input logic p, input logic [4:0] n);
        if (n == 5'd31) return 64'd0;
        if (p && n >= 5'd8 && n <= 5'd14) return m_ovl[n - 5'd8];
        if (p && n == 5'd25) return m_ovl[7];
        return m_norm[n];
    endfunction

    function automatic string req_of(input logic p, input logic [4:0] n);
        if (n == 5'd31) return "R6";
        if (p && n >= 5'd8 && n <= 5'd14) return "R3";
        if (p && n == 5'd25) return "R4";
        if (p) return "R5";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare reads before the edge, then update the model.
    task automatic cyc(input logic p, input logic [4:0] ra, input logic [4:0] rb,
                       input logic we, input logic [4:0] wa, input logic [63:0] wd,
                       input string tag);
        @(negedge clk);
        priv_mode = p; rd_num_a = ra; rd_num_b = rb;
        wr_en = we; wr_num = wa; wr_data = wd;
        #1;
        check((tag == "") ? req_of(p, ra) : tag, rd_data_a, model_rd(p, ra));
        check((tag == "") ? {req_of(p, rb), "/R9"} : tag, rd_data_b, model_rd(p, rb));
        @(posedge clk);
        if (we && wa != 5'd31) begin
            if (p && wa >= 5'd8 && wa <= 5'd14) m_ovl[wa - 5'd8] = wd;
            else if (p && wa == 5'd25) m_ovl[7] = wd;
            else m_norm[wa] = wd;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        for (int i = 0; i < 31; i++) m_norm[i] = 64'd0;
        for (int i = 0; i < 8; i++) m_ovl[i] = 64'd0;
        rst = 1'b1; priv_mode = 0; rd_num_a = 0; rd_num_b = 0;
        wr_en = 0; wr_num = 0; wr_data = 0;
        // dirty some state before reset to show reset clears it
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        cyc(1'b0, 5'd3, 5'd4, 1'b1, 5'd3, 64'hDEAD, "R1");
        cyc(1'b1, 5'd9, 5'd25, 1'b1, 5'd9, 64'hBEEF, "R1");
        @(negedge clk); rst = 1'b1; wr_en = 0;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 31; i++) m_norm[i] = 64'd0;
        for (int i = 0; i < 8; i++) m_ovl[i] = 64'd0;
        // R1: all registers read zero in both modes after reset
        for (int r = 0; r < 32; r += 2) begin
            cyc(1'b0, 5'(r), 5'(r + 1), 1'b0, 5'd0, 64'd0, "R1");
            cyc(1'b1, 5'(r), 5'(r + 1), 1'b0, 5'd0, 64'd0, "R1");
        end
        // R8: same-cycle read sees old value, next cycle the new one
        cyc(1'b0, 5'd5, 5'd5, 1'b1, 5'd5, 64'h1111_2222_3333_4444, "R8");
        cyc(1'b0, 5'd5, 5'd5, 1'b0, 5'd0, 64'd0, "R8");
        // R7: two live copies of register 9 and 25
        cyc(1'b0, 5'd9, 5'd25, 1'b1, 5'd9, 64'hAAAA_0009, "R7");
        cyc(1'b0, 5'd9, 5'd25, 1'b1, 5'd25, 64'hAAAA_0025, "R7");
        cyc(1'b1, 5'd9, 5'd25, 1'b1, 5'd9, 64'hBBBB_0009, "R3");
        cyc(1'b1, 5'd9, 5'd25, 1'b1, 5'd25, 64'hBBBB_0025, "R4");
        cyc(1'b1, 5'd9, 5'd25, 1'b0, 5'd0, 64'd0, "R3");
        cyc(1'b0, 5'd9, 5'd25, 1'b0, 5'd0, 64'd0, "R7");
        cyc(1'b1, 5'd14, 5'd8, 1'b1, 5'd14, 64'hCCCC_0014, "R3");
        cyc(1'b0, 5'd14, 5'd9, 1'b0, 5'd0, 64'd0, "R7");
        // R5: non-redirected number shared between modes
        cyc(1'b1, 5'd7, 5'd15, 1'b1, 5'd15, 64'h5555_0015, "R5");
        cyc(1'b0, 5'd15, 5'd7, 1'b0, 5'd0, 64'd0, "R5");
        // R6: writes to 31 discarded
        cyc(1'b0, 5'd31, 5'd30, 1'b1, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        cyc(1'b1, 5'd31, 5'd31, 1'b1, 5'd31, 64'h1234, "R6");
        cyc(1'b0, 5'd31, 5'd30, 1'b0, 5'd0, 64'd0, "R6");
        // R10: disabled write leaves the target unchanged
        cyc(1'b0, 5'd9, 5'd5, 1'b0, 5'd9, 64'h9999_9999, "R10");
        cyc(1'b0, 5'd9, 5'd5, 1'b0, 5'd0, 64'd0, "R10");
        // random phase, biased toward the redirected window
        for (int k = 0; k < 4000; k++) begin
            logic [4:0] ra, rb, wa;
            logic p;
            p  = $urandom_range(1, 0) == 1;
            ra = ($urandom_range(3, 0) == 0) ? 5'($urandom_range(31, 0)) : 5'($urandom_range(14, 8));
            rb = ($urandom_range(3, 0) == 0) ? 5'd25 : 5'($urandom_range(31, 0));
            wa = ($urandom_range(2, 0) == 0) ? 5'd25 : 5'($urandom_range(31, 0));
            cyc(p, ra, rb, $urandom_range(3, 0) != 0, wa, {$urandom, $urandom}, "");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule